// File: doc/BRIEF.md
# I2C Bus Fault and Arbitration Monitor

This block sits next to an I2C controller. It watches the raw SCL and SDA lines and the controller's own SDA pull-down. The controller tells it the current transfer phase, whether it is acting as master or slave, and whether it is sending or receiving. The monitor reports two kinds of fault:

- **Misplaced START or STOP.** SDA changes while SCL is high in any active transfer phase.
- **Lost arbitration.** The controller has released SDA so the line should read high, but on a rising SCL edge the line is sampled low. This check runs only in the phases where that device is the one driving SDA.

On lost arbitration the monitor sends a one-cycle yield pulse. On that pulse the controller lets go of SCL and SDA and falls back to slave mode.

Both faults are kept as sticky flags. Each flag has its own clear input. One shared enable gates the combined interrupt. SCL and SDA come in asynchronously and pass through a synchronizer of parameter depth. The controller's drive signal is delayed by the same depth so that it lines up with the sampled line. All pins are plain control and status signals. No data stream crosses the block's edge, so there is no valid/ready handshake.

Top module: `i2c_bus_fault_mon`

## Requirements
- R1: After reset, both flags, the interrupt output and the yield pulse are 0.
- R2: In a non-idle phase, a 1-to-0 change of SDA while SCL stays high sets the bus-fault flag.
- R3: In a non-idle phase, a 0-to-1 change of SDA while SCL stays high sets the bus-fault flag.
- R4: An SDA change while SCL is high in the idle phase (phase code 0) leaves the bus-fault flag clear. So does any SDA change while SCL is low.
- R5: At a rising SCL edge inside an arbitration window, if SDA is released by the controller (`sda_pull_i` = 0) and sampled low, the arbitration flag sets and `yield_o` is high for exactly one cycle, in the same cycle the flag sets.
- R6: Arbitration windows use phase codes idle=0, address=1, data=2, ack=3. They are: master transmit in address and data; master receive in address and ack; slave transmit in data; slave receive in ack. Outside these windows no loss is flagged.
- R7: No loss is flagged when the controller pulls SDA low or when SDA is sampled high.
- R8: A set flag stays set until its own clear input is pulsed. A clear pulse affects only its own flag.
- R9: If a flag's set condition and its clear input occur in the same cycle, the flag ends up set.
- R10: `irq_o` is 1 exactly when `err_ie_i` is 1 and at least one flag is set.
- R11: With the default synchronizer depth of 2, a flag is 0 after the second clock edge following the line change and 1 after the third.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Raw SCL line level |
| sda_i | input | 1 | Raw SDA line level |
| sda_pull_i | input | 1 | 1 while the controller pulls SDA low |
| master_i | input | 1 | 1 in master mode, 0 in slave mode |
| tx_i | input | 1 | 1 when the controller transmits, 0 when it receives |
| phase_i | input | 2 | Transfer phase: 0 idle, 1 address, 2 data, 3 ack |
| clr_bus_i | input | 1 | Clears the bus-fault flag |
| clr_arb_i | input | 1 | Clears the arbitration flag |
| err_ie_i | input | 1 | Error interrupt enable |
| bus_fault_o | output | 1 | Sticky misplaced START/STOP flag |
| arb_lost_o | output | 1 | Sticky arbitration-lost flag |
| irq_o | output | 1 | Gated OR of the flags |
| yield_o | output | 1 | One-cycle request to release both lines and return to slave mode |

## Verification
The bench builds the block with its default synchronizer depth of 2. This fixes the three-edge latency from a line change to a flag, so the bench can check exactly that latency. It also lets the bench place a clear pulse on the very edge where a flag sets, to test the set-over-clear rule. Randomly chosen combinations of mode, direction, phase, drive and SDA level cover all sixteen mode/direction/phase cells of the arbitration window table. They also check that SDA toggles under a high SCL are flagged only in active phases.

// File: rtl/i2c_guard_pkg.sv
package i2c_guard_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2,
    PH_ACK  = 2'd3
  } xfer_phase_e;

  localparam int FLAG_BUS  = 0;
  localparam int FLAG_ARB  = 1;
  localparam int NUM_FLAGS = 2;

  // Arbitration applies only where this device itself drives SDA.
  function automatic logic arb_window(input logic master, input logic tx,
                                      input xfer_phase_e ph);
    logic open;
    open = 1'b0;
    unique case ({master, tx})
      2'b11: open = (ph == PH_ADDR) || (ph == PH_DATA); // master sends
      2'b10: open = (ph == PH_ADDR) || (ph == PH_ACK);  // master receives
      2'b01: open = (ph == PH_DATA);                    // slave sends
      2'b00: open = (ph == PH_ACK);                     // slave receives
      default: open = 1'b0;
    endcase
    return open;
  endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int               STAGES  = 2,
  parameter int               WIDTH   = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q,
  output logic [WIDTH-1:0] q_prev
);
  // Each line gets a chain one flop longer than the synchronizer so the
  // previous synchronized sample is available for edge detection.
  for (genvar b = 0; b < WIDTH; b++) begin : g_line
    logic [STAGES:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {(STAGES+1){RST_VAL[b]}};
      else        chain <= {chain[STAGES-1:0], d[b]};
    end
    assign q[b]      = chain[STAGES-1];
    assign q_prev[b] = chain[STAGES];
  end
endmodule

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect (
  input  logic scl_now,
  input  logic scl_prev,
  input  logic sda_now,
  input  logic sda_prev,
  input  logic xfer_active,
  output logic scl_rise,
  output logic fault_det
);
  logic scl_held_high;
  logic stray_start;
  logic stray_stop;

  assign scl_rise      = scl_now & ~scl_prev;
  assign scl_held_high = scl_now & scl_prev;
  assign stray_start   = scl_held_high & sda_prev & ~sda_now;
  assign stray_stop    = scl_held_high & ~sda_prev & sda_now;
  assign fault_det     = xfer_active & (stray_start | stray_stop);
endmodule

// File: rtl/i2c_arb_check.sv
module i2c_arb_check
  import i2c_guard_pkg::*;
#(
  parameter int DELAY = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_rise,
  input  logic        sda_now,
  input  logic        pull_raw,
  input  logic        master,
  input  logic        tx,
  input  xfer_phase_e phase,
  output logic        loss_det,
  output logic        yield_q
);
  // Delay the own-drive signal by the synchronizer depth so it lines up
  // with the sampled SDA level.
  logic [DELAY-1:0] pull_dly;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pull_dly <= '0;
    else        pull_dly <= {pull_dly[DELAY-2:0], pull_raw};
  end

  logic pull_aligned;
  assign pull_aligned = pull_dly[DELAY-1];

  assign loss_det = scl_rise & arb_window(master, tx, phase)
                  & ~pull_aligned & ~sda_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) yield_q <= 1'b0;
    else        yield_q <= loss_det;
  end

  // R5
  yield_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    yield_q |=> !yield_q);
endmodule

// File: rtl/i2c_err_flags.sv
module i2c_err_flags #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flags
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    logic f;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) f <= 1'b0;
      else        f <= set[i] | (f & ~clr[i]);
    end
    assign flags[i] = f;

    // R9
    set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set[i] |=> flags[i]);
    // R8
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flags[i] && !clr[i]) |=> flags[i]);
  end
endmodule

// File: rtl/i2c_bus_fault_mon.sv
module i2c_bus_fault_mon
  import i2c_guard_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic       sda_pull_i,
  input  logic       master_i,
  input  logic       tx_i,
  input  logic [1:0] phase_i,
  input  logic       clr_bus_i,
  input  logic       clr_arb_i,
  input  logic       err_ie_i,
  output logic       bus_fault_o,
  output logic       arb_lost_o,
  output logic       irq_o,
  output logic       yield_o
);
  localparam int LINES = 2;
  localparam int L_SCL = 1;
  localparam int L_SDA = 0;

  xfer_phase_e phase;
  assign phase = xfer_phase_e'(phase_i);

  logic [LINES-1:0] line_now, line_prev;

  i2c_line_sync #(.STAGES(SYNC_STAGES), .WIDTH(LINES), .RST_VAL('1)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .d      ({scl_i, sda_i}),
    .q      (line_now),
    .q_prev (line_prev)
  );

  logic scl_rise, fault_det;

  i2c_cond_detect u_cond (
    .scl_now     (line_now[L_SCL]),
    .scl_prev    (line_prev[L_SCL]),
    .sda_now     (line_now[L_SDA]),
    .sda_prev    (line_prev[L_SDA]),
    .xfer_active (phase != PH_IDLE),
    .scl_rise    (scl_rise),
    .fault_det   (fault_det)
  );

  logic loss_det;

  i2c_arb_check #(.DELAY(SYNC_STAGES)) u_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_rise (scl_rise),
    .sda_now  (line_now[L_SDA]),
    .pull_raw (sda_pull_i),
    .master   (master_i),
    .tx       (tx_i),
    .phase    (phase),
    .loss_det (loss_det),
    .yield_q  (yield_o)
  );

  logic [NUM_FLAGS-1:0] set_v, clr_v, flag_v;
  always_comb begin
    set_v = '0;
    clr_v = '0;
    set_v[FLAG_BUS] = fault_det;
    set_v[FLAG_ARB] = loss_det;
    clr_v[FLAG_BUS] = clr_bus_i;
    clr_v[FLAG_ARB] = clr_arb_i;
  end

  i2c_err_flags #(.N(NUM_FLAGS)) u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (set_v),
    .clr   (clr_v),
    .flags (flag_v)
  );

  assign bus_fault_o = flag_v[FLAG_BUS];
  assign arb_lost_o  = flag_v[FLAG_ARB];
  assign irq_o       = err_ie_i & (|flag_v);

  // R5
  yield_with_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    yield_o |-> arb_lost_o);
  // R4
  fault_needs_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_fault_o) |-> ($past(phase_i) != 2'd0));
endmodule

// File: tb/tb_i2c_bus_fault_mon.sv
module tb_i2c_bus_fault_mon;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1, sda = 1'b1, pull = 1'b0, master = 1'b0, tx = 1'b0;
  logic [1:0] phase = 2'd0;
  logic clr_bus = 1'b0, clr_arb = 1'b0, ie = 1'b0;
  logic bus_fault, arb_lost, irq, yield_p;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  i2c_bus_fault_mon dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda), .sda_pull_i(pull),
    .master_i(master), .tx_i(tx), .phase_i(phase), .clr_bus_i(clr_bus),
    .clr_arb_i(clr_arb), .err_ie_i(ie), .bus_fault_o(bus_fault),
    .arb_lost_o(arb_lost), .irq_o(irq), .yield_o(yield_p)
  );

  function automatic bit exp_window(bit m, bit t, logic [1:0] ph);
    if (m && t)   return (ph == 2'd1) || (ph == 2'd2);
    if (m && !t)  return (ph == 2'd1) || (ph == 2'd3);
    if (!m && t)  return ph == 2'd2;
    return ph == 2'd3;
  endfunction

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_all();
    clr_bus = 1'b1; clr_arb = 1'b1;
    tick(1);
    clr_bus = 1'b0; clr_arb = 1'b0;
    tick(1);
  endtask

  // Raise SCL and count yield cycles over the following window.
  task automatic rise_and_count(output int ycount);
    ycount = 0;
    scl = 1'b1;
    for (int k = 0; k < 6; k++) begin
      tick(1);
      if (yield_p) ycount++;
    end
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    int yc;
    int unsigned seed;
    seed = 32'd1357;
    void'($urandom(seed));
    tick(3);
    // R1 reset state
    check("R1 bus_fault", bus_fault, 0);
    check("R1 arb_lost", arb_lost, 0);
    check("R1 irq", irq, 0);
    check("R1 yield", yield_p, 0);
    rst_n = 1'b1;
    tick(4);

    // R2 and R11: stray start in data phase
    phase = 2'd2; pull = 1'b1;
    tick(4);
    sda = 1'b0;
    tick(2);
    check("R11 not yet", bus_fault, 0);
    tick(1);
    check("R2 stray start", bus_fault, 1);
    // R10
    check("R10 irq disabled", irq, 0);
    ie = 1'b1; tick(1);
    check("R10 irq enabled", irq, 1);
    // R8: clearing arbitration flag leaves bus fault alone
    clr_arb = 1'b1; tick(1); clr_arb = 1'b0; tick(1);
    check("R8 other clear", bus_fault, 1);
    tick(5);
    check("R8 sticky", bus_fault, 1);
    clr_bus = 1'b1; tick(1); clr_bus = 1'b0; tick(1);
    check("R8 own clear", bus_fault, 0);
    check("R10 irq idle", irq, 0);

    // R3 stray stop
    sda = 1'b1;
    tick(4);
    check("R3 stray stop", bus_fault, 1);
    clear_all();

    // R4 legal start/stop in idle phase
    phase = 2'd0;
    sda = 1'b0; tick(4);
    sda = 1'b1; tick(4);
    check("R4 idle start/stop", bus_fault, 0);
    // R4 toggles while SCL low
    phase = 2'd2;
    scl = 1'b0; tick(4);
    sda = 1'b0; tick(4);
    sda = 1'b1; tick(4);
    check("R4 scl low", bus_fault, 0);
    scl = 1'b1; tick(4);
    check("R7 pulled no loss", arb_lost, 0);

    // R9 set wins over clear
    sda = 1'b0;
    tick(2);
    clr_bus = 1'b1;
    tick(1);
    clr_bus = 1'b0;
    check("R9 set beats clear", bus_fault, 1);
    phase = 2'd0; sda = 1'b1; tick(4);
    clear_all();

    // R5 directed loss: master transmit data, released, SDA low
    scl = 1'b0; tick(4);
    master = 1'b1; tx = 1'b1; phase = 2'd2; pull = 1'b0; sda = 1'b0;
    tick(4);
    rise_and_count(yc);
    check("R5 arb flag", arb_lost, 1);
    check("R5 yield one cycle", yc, 1);
    check("R10 irq arb", irq, 1);
    scl = 1'b0; tick(4);
    sda = 1'b1; tick(4);
    clear_all();

    // R6/R7 random arbitration windows
    for (int it = 0; it < 160; it++) begin
      bit m, t, p, s, exp;
      logic [1:0] ph;
      m = 1'($urandom); t = 1'($urandom); p = 1'($urandom); s = 1'($urandom);
      ph = 2'($urandom);
      scl = 1'b0; tick(3);
      master = m; tx = t; phase = ph; pull = p; sda = s;
      tick(4);
      rise_and_count(yc);
      exp = exp_window(m, t, ph) && !p && !s;
      check(exp_window(m, t, ph) ? "R7 arb drive/level" : "R6 arb window",
            arb_lost, exp);
      check("R5 yield count", yc, exp ? 1 : 0);
      scl = 1'b0; tick(3);
      phase = 2'd0; sda = 1'b1; pull = 1'b0; tick(3);
      clear_all();
    end

    // R2/R3/R4 random SDA toggles under high SCL
    for (int it = 0; it < 80; it++) begin
      logic [1:0] ph;
      bit s;
      ph = 2'($urandom); s = 1'($urandom);
      scl = 1'b0; pull = 1'b1; tick(3);
      phase = ph; sda = s; tick(3);
      scl = 1'b1; tick(4);
      sda = ~s; tick(4);
      check(ph == 2'd0 ? "R4 idle toggle" : (s ? "R2 random" : "R3 random"),
            bus_fault, (ph != 2'd0) ? 1 : 0);
      scl = 1'b0; tick(3);
      phase = 2'd0; sda = 1'b1; tick(3);
      clear_all();
    end

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule